// File: doc/BRIEF.md
# Flash Completion Poller

This block runs on the host side of a parallel NOR flash. After software or another engine has issued a program or erase command, it waits for the embedded operation to finish, then returns a verdict. A one-cycle `start` pulse gives it the address to poll and the expected value of status bit 7. For a program, that value is the bit-7 value being written. For an erase, it is forced to one.

The block then issues reads through a plain request/acknowledge memory port, with one transfer in flight at a time. Each returned word is judged on bit 7, the data-complement indicator, and bit 5, the exceeded-time indicator. Bit 7 can flip in the same read where bit 5 first shows up, so a set bit 5 never ends the wait at once. One more read is made, and bit 7 of that read alone decides the result.

When bit 7 shows true data, one further read is made so that the reported word comes from a cycle after the status settled. The block ends with a one-cycle `done` pulse. Either `pass` or `fail` is then raised and held, together with the final word, until the next accepted start. An optional limit on the number of polling reads ends the wait with a failure if the device never responds.

Top module: `flash_poll_top`

## Requirements
- R1: After reset, `done`, `pass`, `fail`, `busy` and `memReq` are all 0.
- R2: A `start` seen while idle latches `addrIn` as the poll address. It latches the expected bit-7 value as 1 when `isErase` is 1, and as `expectBit` otherwise. It clears `pass` and `fail` and makes `busy` 1.
- R3: A transfer completes in a cycle where `memReq` and `memAck` are both 1. While the block is busy, `memReq` is 1 and `memAddr` equals the latched address. `memReq` stays 1 with a stable address until acknowledged.
- R4: When a polling read returns bit 7 equal to the expected value, the block makes exactly one more read. It then finishes with `pass`, and `resultData` holds the word of that later read.
- R5: When a polling read returns bit 7 unequal to the expected value and bit 5 equal to 0, the block makes another polling read, unless R7 applies.
- R6: When a polling read returns bit 7 unequal to the expected value and bit 5 equal to 1, one recheck read follows. If its bit 7 matches, the flow of R4 follows. If not, the block finishes with `fail`, and `resultData` holds the recheck word.
- R7: With `MAX_POLLS` nonzero, the rule covers the `MAX_POLLS`-th polling read. If that read has bit 7 unequal and bit 5 equal to 0, the block finishes with `fail`, and `resultData` holds that word. A value of 0 removes the limit.
- R8: `done` is a single-cycle pulse in the cycle after the last acknowledged transfer. With it, exactly one of `pass` and `fail` is 1. Both flags and `resultData` hold until the next accepted start.
- R9: A `start` while `busy` is 1 has no effect: addresses, read count and result are those of the running operation, and only one `done` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (one-cycle pulse) |
| isErase | input | 1 | Operation being waited on is an erase |
| expectBit | input | 1 | Bit 7 of the programmed datum (program only) |
| addrIn | input | AW | Address to poll |
| memReq | output | 1 | Read request |
| memAddr | output | AW | Read address |
| memAck | input | 1 | Read acknowledge; `memRdata` valid with it |
| memRdata | input | DW | Returned word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation completed successfully (held) |
| fail | output | 1 | Operation failed or timed out (held) |
| resultData | output | DW | Word from the last read of the operation (held) |

## Verification
The assertions take for granted that the memory side raises `memAck` only while `memReq` is 1. They also assume that `memRdata` is meaningful only in acknowledged cycles. The bench memory model keeps to this: it raises the acknowledge at a falling edge only when a request is pending, after a latency of zero to two cycles. It drops the acknowledge at the next falling edge. The bench also pulses `start` only from the idle state, apart from the deliberate mid-operation pulse that exercises R9.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  localparam int DATA_BIT   = 7;  // complement-of-data status bit
  localparam int EXPIRY_BIT = 5;  // exceeded-time status bit

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_POLL  = 2'd1,
    ST_RECHK = 2'd2,
    ST_FINAL = 2'd3
  } pollState_t;

  typedef struct packed {
    logic load;      // accept a new operation
    logic cntInc;    // one more unfinished polling read
    logic capture;   // store the returned word as result
    logic finPass;   // finish with success
    logic finFail;   // finish with failure
  } ctrlStrobe_t;

  typedef struct packed {
    logic b7Match;   // returned bit 7 equals expected
    logic b5Set;     // returned bit 5 is one
    logic limitHit;  // current read is the last allowed polling read
  } dpStatus_t;

endpackage

// File: rtl/flash_poll_dp.sv
module flash_poll_dp
  import flash_poll_pkg::*;
#(
  parameter int AW        = 23,
  parameter int DW        = 16,
  parameter int MAX_POLLS = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strobe,
  input  logic          isErase,
  input  logic          expectBit,
  input  logic [AW-1:0] addrIn,
  input  logic [DW-1:0] memRdata,
  output dpStatus_t     status,
  output logic [AW-1:0] memAddr,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [DW-1:0] resultData
);

  logic [AW-1:0] addrReg;
  logic          expReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      expReg  <= 1'b0;
    end else if (strobe.load) begin
      addrReg <= addrIn;
      expReg  <= isErase ? 1'b1 : expectBit;
    end
  end

  assign memAddr        = addrReg;
  assign status.b7Match = (memRdata[DATA_BIT] == expReg);
  assign status.b5Set   = memRdata[EXPIRY_BIT];

  generate
    if (MAX_POLLS > 0) begin : gLimit
      localparam int CW = $clog2(MAX_POLLS + 1);
      logic [CW-1:0] pollCnt;
      always_ff @(posedge clk) begin
        if (!rstN || strobe.load) pollCnt <= '0;
        else if (strobe.cntInc)   pollCnt <= pollCnt + 1'b1;
      end
      assign status.limitHit = (pollCnt == CW'(MAX_POLLS - 1));
    end else begin : gNoLimit
      assign status.limitHit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done       <= 1'b0;
      pass       <= 1'b0;
      fail       <= 1'b0;
      resultData <= '0;
    end else begin
      done <= strobe.finPass | strobe.finFail;
      if (strobe.load) begin
        pass <= 1'b0;
        fail <= 1'b0;
      end else begin
        if (strobe.finPass) pass <= 1'b1;
        if (strobe.finFail) fail <= 1'b1;
      end
      if (strobe.capture) resultData <= memRdata;
    end
  end

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        memAck,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        memReq,
  output logic        busy
);

  pollState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign memReq = (state != ST_IDLE);
  assign busy   = (state != ST_IDLE);

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          nextState   = ST_POLL;
        end
      end
      ST_POLL: begin
        if (memAck) begin
          if (status.b7Match) begin
            nextState = ST_FINAL;
          end else if (status.b5Set) begin
            nextState = ST_RECHK;
          end else if (status.limitHit) begin
            strobe.capture = 1'b1;
            strobe.finFail = 1'b1;
            nextState      = ST_IDLE;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
      end
      ST_RECHK: begin
        if (memAck) begin
          if (status.b7Match) begin
            nextState = ST_FINAL;
          end else begin
            strobe.capture = 1'b1;
            strobe.finFail = 1'b1;
            nextState      = ST_IDLE;
          end
        end
      end
      ST_FINAL: begin
        if (memAck) begin
          strobe.capture = 1'b1;
          strobe.finPass = 1'b1;
          nextState      = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/flash_poll_top.sv
module flash_poll_top
  import flash_poll_pkg::*;
#(
  parameter int AW        = 23,
  parameter int DW        = 16,
  parameter int MAX_POLLS = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          isErase,
  input  logic          expectBit,
  input  logic [AW-1:0] addrIn,
  output logic          memReq,
  output logic [AW-1:0] memAddr,
  input  logic          memAck,
  input  logic [DW-1:0] memRdata,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [DW-1:0] resultData
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  flash_poll_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .memAck (memAck),
    .status (status),
    .strobe (strobe),
    .memReq (memReq),
    .busy   (busy)
  );

  flash_poll_dp #(
    .AW        (AW),
    .DW        (DW),
    .MAX_POLLS (MAX_POLLS)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .isErase    (isErase),
    .expectBit  (expectBit),
    .addrIn     (addrIn),
    .memRdata   (memRdata),
    .status     (status),
    .memAddr    (memAddr),
    .done       (done),
    .pass       (pass),
    .fail       (fail),
    .resultData (resultData)
  );

endmodule

// File: rtl/flash_poll_chk.sv
module flash_poll_chk #(
  parameter int AW = 23
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          memReq,
  input logic          memAck,
  input logic [AW-1:0] memAddr,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          fail
);

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

  a_r3_addr_fixed: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!busy || $stable(memAddr)));

  a_r3_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_one_verdict: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pass != fail));

  a_r8_verdict_held: assert property (@(posedge clk) disable iff (!rstN)
    !(start && !busy) |=> (done || ($stable(pass) && $stable(fail))));

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !pass && !fail));

endmodule

bind flash_poll_top flash_poll_chk #(.AW(AW)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .memReq  (memReq),
  .memAck  (memAck),
  .memAddr (memAddr),
  .busy    (busy),
  .done    (done),
  .pass    (pass),
  .fail    (fail)
);

// File: tb/tb_flash_poll_top.sv
`timescale 1ns/1ps
module tb_flash_poll_top;

  localparam int AW   = 12;
  localparam int DW   = 16;
  localparam int MAXP = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          isErase = 1'b0;
  logic          expectBit = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic          memReq;
  logic [AW-1:0] memAddr;
  logic          memAck = 1'b0;
  logic [DW-1:0] memRdata = '0;
  logic          busy, done, pass, fail;
  logic [DW-1:0] resultData;

  int tests = 0;
  int fails = 0;

  // scenario globals used by the memory model
  int            gMis = 0, gT5 = -1, gLat = 0;
  logic          gExp = 1'b0;
  logic [AW-1:0] gAddr = '0;
  int            idx = 0, wcnt = 0, addrErr = 0, doneCnt = 0;

  always #2.5 clk = ~clk;

  flash_poll_top #(.AW(AW), .DW(DW), .MAX_POLLS(MAXP)) dut (
    .clk(clk), .rstN(rstN), .start(start), .isErase(isErase),
    .expectBit(expectBit), .addrIn(addrIn), .memReq(memReq),
    .memAddr(memAddr), .memAck(memAck), .memRdata(memRdata),
    .busy(busy), .done(done), .pass(pass), .fail(fail),
    .resultData(resultData)
  );

  // bit 7 matches from read nMis on; bit 5 set from read t5 on (t5 < 0: never)
  function automatic logic [15:0] wordFor(int k, int nMis, int t5, logic e);
    logic [15:0] w;
    w    = 16'h1234 + 16'(k) * 16'h0B05;
    w[7] = (k >= nMis) ? e : ~e;
    w[5] = (t5 >= 0 && k >= t5);
    return w;
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      memAck = 1'b0; wcnt = 0;
    end else if (memAck) begin
      memAck = 1'b0;
      idx++;
    end else if (memReq) begin
      if (wcnt >= gLat) begin
        if (memAddr != gAddr) addrErr++;
        memRdata = wordFor(idx, gMis, gT5, gExp);
        memAck   = 1'b1;
        wcnt     = 0;
      end else begin
        wcnt++;
      end
    end
    if (rstN && done) doneCnt++;
  end

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic runOp(int nMis, int t5, int mode, int lat, logic [AW-1:0] a);
    int eReads; bit ePass; logic [15:0] eWord; logic e; int cyc;
    e = (mode == 2) ? 1'b1 : logic'(mode);
    eReads = 0; ePass = 0; eWord = '0;
    for (int k = 0; k < 64; k++) begin
      if (k >= nMis) begin
        eReads = k + 2; ePass = 1; eWord = wordFor(k + 1, nMis, t5, e); break;
      end
      if (t5 >= 0 && k >= t5) begin
        if (k + 1 >= nMis) begin
          eReads = k + 3; ePass = 1; eWord = wordFor(k + 2, nMis, t5, e);
        end else begin
          eReads = k + 2; ePass = 0; eWord = wordFor(k + 1, nMis, t5, e);
        end
        break;
      end
      if (k + 1 == MAXP) begin
        eReads = k + 1; ePass = 0; eWord = wordFor(k, nMis, t5, e); break;
      end
    end
    gMis = nMis; gT5 = t5; gExp = e; gLat = lat; gAddr = a;
    idx = 0; addrErr = 0; doneCnt = 0;
    @(negedge clk);
    isErase = (mode == 2); expectBit = (mode == 2) ? ~e : e; addrIn = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    check(busy && !pass && !fail, "R2", "busy/clear after start", {busy, pass, fail}, 3'b100);
    // R9: start pulse while busy with a different address and polarity
    @(negedge clk);
    if (busy) begin
      addrIn = ~a; isErase = ~isErase; expectBit = ~expectBit; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk); #1; cyc++;
    end
    check(cyc < 2000, "R8", "done seen", cyc, 0);
    check(pass == ePass && fail == !ePass, "R4 R6 R7", "verdict", {pass, fail}, {ePass, !ePass});
    check(resultData == eWord, "R4 R6 R7", "resultData", resultData, eWord);
    check(idx == eReads, "R5", "read count", idx, eReads);
    check(addrErr == 0, "R3 R9", "address errors", addrErr, 0);
    repeat (3) @(negedge clk);
    #1;
    check(doneCnt == 1 && !done, "R8 R9", "single done pulse", doneCnt, 1);
    check(pass == ePass && fail == !ePass && resultData == eWord && !memReq,
          "R8", "verdict held", {pass, fail}, {ePass, !ePass});
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int t5s[4];
    int n;
    t5s[0] = -1; t5s[1] = 0; t5s[2] = 2; t5s[3] = 5;
    repeat (3) @(negedge clk);
    #1;
    check(!done && !pass && !fail && !busy && !memReq, "R1", "reset outputs",
          {done, pass, fail, busy, memReq}, 0);
    rstN = 1'b1;
    n = 0;
    for (int mode = 0; mode < 3; mode++)
      for (int nMis = 0; nMis < 9; nMis++)
        for (int t = 0; t < 4; t++) begin
          runOp(nMis, t5s[t], mode, n % 3, AW'(12'h0A5 + n * 37));
          n++;
        end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule